// File: doc/BRIEF.md
# Interlaced Field Parity Status Generator

This block runs the vertical raster timing of a video output. It counts clocks within each scanline, scanlines within each field, and fields. From these counts it produces two status flags that software polls. The first, `line_odd`, gives the parity of the frame-buffer lines being scanned out. The second, `field_flag`, is a field indicator. The block also drives a vertical-blanking indicator and the current scanline number.

Software sets the block up through a host-write strobe. Each write loads three values: an interlace enable, a high vertical-resolution select, and a vertical display start offset.

Output is interlaced only when both mode bits are set. In that case successive fields scan even lines and then odd lines. During vertical blanking the parity flag does not follow the field. It shows the least significant bit of the display offset instead. The flags are recomputed only at the start of each scanline, so a register write reaches them one scanline late at most.

Top module: `field_parity_status`

## Requirements
- R1: After reset, `line_count` is 0, `vblank` is 0, `line_odd` is 0 and `field_flag` is 1.
- R2: `line_count` advances by one every `CLKS_PER_LINE` clocks. After `LINES_PER_FIELD-1` it wraps to 0, which starts a new field.
- R3: `vblank` is 1 exactly while `line_count` is at least `ACTIVE_LINES`, which places the blanking window at the end of each field.
- R4: Interlaced output needs both `cfg_interlace` and `cfg_hires` at 1. With either bit alone the output is progressive: `line_odd` is 0 in the active area of every field and `field_flag` is 1.
- R5: In interlaced output, the active-area value of `line_odd` alternates from field to field (1 = odd lines, 0 = even lines).
- R6: On every blanking scanline, `line_odd` equals bit 0 of the registered display offset, in both interlaced and progressive output.
- R7: `line_odd` and `field_flag` change only on the first clock of a scanline. An offset or mode write made in the middle of a line affects them at the next line start and not before.
- R8: `field_flag` is 1 throughout progressive output and toggles once per field in interlaced output. During the active area it is always the inverse of `line_odd`.
- R9: The mode and offset inputs are captured only in a cycle where `cfg_we` is 1. Changes on those inputs at any other time have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Host-write strobe that loads the mode and offset inputs |
| cfg_interlace | input | 1 | Interlace enable |
| cfg_hires | input | 1 | High vertical-resolution select |
| cfg_voffset | input | OFFS_W (10) | Vertical display start offset |
| line_odd | output | 1 | Line-parity flag for the lines being scanned out |
| field_flag | output | 1 | Field flag |
| vblank | output | 1 | High during vertical blanking |
| line_count | output | LINE_W (9) | Current scanline within the field |

## Verification
The bench checks that the parity flag switches over to the offset bit at the first blanking line and switches back to the field parity at line 0. A design that updated the flag at the field wrap alone would keep the wrong parity for the whole blanking window.

The bench also writes the offset in the middle of a blanking line and checks that nothing moves until the next line starts. An immediate update would fail that check.

Each mode bit is enabled on its own, which catches a design that interlaces on either bit. The cfg inputs are also changed without the strobe, which exposes a design that tracks the pins directly.

Finally, the inverse relation between the two flags is checked in the active area across mode changes. This catches a field flag that is refreshed on a different schedule from the parity flag.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef struct packed {
    logic ilace_en;
    logic hires_en;
  } fps_mode_t;

  function automatic logic fps_is_interlaced(fps_mode_t m);
    return m.ilace_en & m.hires_en;
  endfunction

endpackage

// File: rtl/fps_cfg_regs.sv
module fps_cfg_regs
  import fps_pkg::*;
#(
  parameter int OFFS_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  fps_mode_t         mode_in,
  input  logic [OFFS_W-1:0] voff_in,
  output fps_mode_t         mode_q,
  output logic [OFFS_W-1:0] voff_q
);

  fps_mode_t         mode_d;
  logic [OFFS_W-1:0] voff_d;

  always_comb begin
    mode_d = mode_q;
    voff_d = voff_q;
    if (we) begin
      mode_d = mode_in;
      voff_d = voff_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      voff_q <= '0;
    end else begin
      mode_q <= mode_d;
      voff_q <= voff_d;
    end
  end

  // R9: without a strobe, the held configuration does not move
  a_r9_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(mode_q) && $stable(voff_q)));

endmodule

// File: rtl/fps_raster_timer.sv
module fps_raster_timer #(
  parameter int CLKS_PER_LINE   = 8,
  parameter int LINES_PER_FIELD = 312,
  parameter int ACTIVE_LINES    = 288,
  parameter int PIX_W  = (CLKS_PER_LINE > 1) ? $clog2(CLKS_PER_LINE) : 1,
  parameter int LINE_W = (LINES_PER_FIELD > 1) ? $clog2(LINES_PER_FIELD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              line_tick,
  output logic              field_wrap,
  output logic              next_blank,
  output logic              blank,
  output logic [LINE_W-1:0] line_q
);

  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(CLKS_PER_LINE - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES_PER_FIELD - 1);
  localparam logic [LINE_W-1:0] ACT_LIM   = LINE_W'(ACTIVE_LINES);

  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [LINE_W-1:0] line_d, line_nxt;

  always_comb begin
    line_tick  = (pix_q == PIX_LAST);
    field_wrap = line_tick && (line_q == LINE_LAST);
    line_nxt   = field_wrap ? '0 : line_q + LINE_W'(1);
    next_blank = (line_nxt >= ACT_LIM);
    blank      = (line_q >= ACT_LIM);
    pix_d      = line_tick ? '0 : pix_q + PIX_W'(1);
    line_d     = line_tick ? line_nxt : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end

  // R2: the last line of a field is followed by line 0
  a_r2_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && line_q == LINE_LAST) |=> (line_q == '0));

  // R2: the line number never leaves the field
  a_r2_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= LINE_LAST);

  // R3: blanking starts on the line after the last active one
  a_r3_blank_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && line_q == ACT_LIM - LINE_W'(1)) |=> blank);

endmodule

// File: rtl/fps_parity_gen.sv
module fps_parity_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick,
  input  logic field_wrap,
  input  logic next_blank,
  input  logic interlaced,
  input  logic voff_lsb,
  output logic line_odd,
  output logic field_flag
);

  logic field_odd_q, field_odd_d;
  logic act_par;
  logic line_odd_d, field_flag_d;

  always_comb begin
    field_odd_d  = field_wrap ? (interlaced & ~field_odd_q) : field_odd_q;
    act_par      = interlaced & field_odd_d;
    line_odd_d   = line_odd;
    field_flag_d = field_flag;
    if (line_tick) begin
      line_odd_d   = next_blank ? voff_lsb : act_par;
      field_flag_d = ~act_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_odd_q <= 1'b0;
      line_odd    <= 1'b0;
      field_flag  <= 1'b1;
    end else begin
      field_odd_q <= field_odd_d;
      line_odd    <= line_odd_d;
      field_flag  <= field_flag_d;
    end
  end

  // R7: the flags move only on a line boundary
  a_r7_hold_midline: assert property (@(posedge clk) disable iff (!rst_n)
    !line_tick |=> ($stable(line_odd) && $stable(field_flag)));

  // R6: a blanking line shows the offset bit
  a_r6_blank_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && next_blank) |=> (line_odd == $past(voff_lsb)));

  // R8: progressive output keeps the field flag set
  a_r8_prog_field: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && !interlaced) |=> field_flag);

  // R5: interlaced fields alternate parity
  a_r5_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (field_wrap && interlaced) |=> (field_odd_q != $past(field_odd_q)));

endmodule

// File: rtl/field_parity_status.sv
module field_parity_status
  import fps_pkg::*;
#(
  parameter int CLKS_PER_LINE   = 8,
  parameter int LINES_PER_FIELD = 312,
  parameter int ACTIVE_LINES    = 288,
  parameter int OFFS_W          = 10,
  parameter int LINE_W = (LINES_PER_FIELD > 1) ? $clog2(LINES_PER_FIELD) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_interlace,
  input  logic              cfg_hires,
  input  logic [OFFS_W-1:0] cfg_voffset,
  output logic              line_odd,
  output logic              field_flag,
  output logic              vblank,
  output logic [LINE_W-1:0] line_count
);

  logic rst_s1, rst_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  fps_mode_t         mode_in, mode_q;
  logic [OFFS_W-1:0] voff_q;
  logic              line_tick, field_wrap, next_blank;

  always_comb begin
    mode_in.ilace_en = cfg_interlace;
    mode_in.hires_en = cfg_hires;
  end

  fps_cfg_regs #(.OFFS_W(OFFS_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_s2),
    .we      (cfg_we),
    .mode_in (mode_in),
    .voff_in (cfg_voffset),
    .mode_q  (mode_q),
    .voff_q  (voff_q)
  );

  fps_raster_timer #(
    .CLKS_PER_LINE   (CLKS_PER_LINE),
    .LINES_PER_FIELD (LINES_PER_FIELD),
    .ACTIVE_LINES    (ACTIVE_LINES),
    .LINE_W          (LINE_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_s2),
    .line_tick  (line_tick),
    .field_wrap (field_wrap),
    .next_blank (next_blank),
    .blank      (vblank),
    .line_q     (line_count)
  );

  fps_parity_gen u_parity (
    .clk        (clk),
    .rst_n      (rst_s2),
    .line_tick  (line_tick),
    .field_wrap (field_wrap),
    .next_blank (next_blank),
    .interlaced (fps_is_interlaced(mode_q)),
    .voff_lsb   (voff_q[0]),
    .line_odd   (line_odd),
    .field_flag (field_flag)
  );

  // R8: in the active area the field flag is the inverse of the parity flag
  a_r8_active_opposite: assert property (@(posedge clk) disable iff (!rst_s2)
    !vblank |-> (field_flag != line_odd));

endmodule

// File: tb/field_parity_status_tb.sv
module field_parity_status_tb;

  localparam int CPL = 8;
  localparam int LPF = 312;
  localparam int ACT = 288;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_interlace = 1'b0;
  logic       cfg_hires = 1'b0;
  logic [9:0] cfg_voffset = '0;
  logic       line_odd, field_flag, vblank;
  logic [8:0] line_count;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;

  field_parity_status u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_interlace(cfg_interlace),
    .cfg_hires(cfg_hires), .cfg_voffset(cfg_voffset), .line_odd(line_odd),
    .field_flag(field_flag), .vblank(vblank), .line_count(line_count)
  );

  // behavioural reference
  int m_rs, m_pix, m_line;
  bit m_il, m_hi, m_v0, m_fodd, m_par, m_ff;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_pix = 0; m_line = 0;
      m_il = 0; m_hi = 0; m_v0 = 0; m_fodd = 0; m_par = 0; m_ff = 1;
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      bit ilaced;
      ilaced = m_il && m_hi;
      if (m_pix == CPL - 1) begin
        m_pix = 0;
        m_line++;
        if (m_line == LPF) begin
          m_line = 0;
          m_fodd = ilaced ? !m_fodd : 1'b0;
        end
        m_par = (m_line >= ACT) ? m_v0 : (ilaced && m_fodd);
        m_ff  = !(ilaced && m_fodd);
      end else begin
        m_pix++;
      end
      if (cfg_we) begin
        m_il = cfg_interlace; m_hi = cfg_hires; m_v0 = cfg_voffset[0];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R2 line_count", int'(line_count), m_line);
      chk("R3 vblank", int'(vblank), int'(m_line >= ACT));
      chk("R5 R6 R7 line_odd", int'(line_odd), int'(m_par));
      chk("R8 field_flag", int'(field_flag), int'(m_ff));
    end
  end

  task automatic write_cfg(input bit il, input bit hi, input logic [9:0] vo);
    @(negedge clk); #1;
    cfg_interlace = il; cfg_hires = hi; cfg_voffset = vo; cfg_we = 1'b1;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_line(input int n);
    @(negedge clk);
    while (int'(line_count) != n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit p0;
    cmp_en = 1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 line_count", int'(line_count), 0);
    chk("R1 vblank", int'(vblank), 0);
    chk("R1 line_odd", int'(line_odd), 0);
    chk("R1 field_flag", int'(field_flag), 1);
    repeat (4) @(negedge clk);

    // progressive with odd offset: blanking shows offset bit
    write_cfg(1'b0, 1'b0, 10'd3);
    wait_line(ACT + 1);
    chk("R6 progressive blank parity", int'(line_odd), 1);

    // R4: interlace bit alone stays progressive
    write_cfg(1'b1, 1'b0, 10'd0);
    wait_line(5);
    chk("R4 ilace only active parity", int'(line_odd), 0);
    wait_line(ACT + 1); wait_line(5);
    chk("R4 ilace only next field parity", int'(line_odd), 0);
    chk("R4 ilace only field flag", int'(field_flag), 1);

    // R4: hires bit alone stays progressive
    write_cfg(1'b0, 1'b1, 10'd0);
    wait_line(ACT + 1); wait_line(5);
    chk("R4 hires only active parity", int'(line_odd), 0);

    // interlaced: alternating parity
    write_cfg(1'b1, 1'b1, 10'd0);
    wait_line(ACT + 1); wait_line(5);
    p0 = line_odd;
    wait_line(ACT + 1); wait_line(5);
    chk("R5 parity alternates", int'(line_odd), int'(!p0));
    chk("R8 field flag inverse", int'(field_flag), int'(p0));
    wait_line(ACT + 1); wait_line(5);
    chk("R5 parity returns", int'(line_odd), int'(p0));

    // R7: mid-line offset write takes effect at next line
    wait_line(ACT + 2);
    write_cfg(1'b1, 1'b1, 10'd1);
    @(negedge clk);
    chk("R7 no midline change", int'(line_odd), 0);
    wait_line(ACT + 3);
    chk("R6 R7 new offset at next line", int'(line_odd), 1);

    // R9: inputs changed without strobe are ignored
    @(negedge clk); #1;
    cfg_voffset = 10'd0; cfg_interlace = 1'b0;
    wait_line(ACT + 4);
    chk("R9 offset ignored", int'(line_odd), 1);
    wait_line(5); p0 = line_odd;
    wait_line(ACT + 1); wait_line(5);
    chk("R9 mode ignored", int'(line_odd), int'(!p0));

    repeat (20) @(negedge clk);
    finish_run();
  end

endmodule